// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

A register-mapped general-purpose I/O port of up to 32 lines. A simple 32-bit register bus (address, write enable, write data, combinational read data) gives access to the sampled pin values, an output value register, a direction register and four interrupt control registers. Every line can raise an interrupt. Each line has its own enable, its own polarity and its own choice of edge or level detection.

Each line's interrupt is steered through a byte-wide routing field to one of `NOUT` interrupt outputs, or to none. Several lines may share one output, and the output carries the OR of their conditions. Incoming pins pass through a two-flop synchroniser before they are read back or examined for edges. The interrupt outputs are registered.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is zero and every interrupt output is low.
- R2: Register bits for lines at or above the configured line count read zero and ignore writes. The words at 0x18 and 0x1C, and routing words for absent lines, read zero.
- R3: A read at 0x00 shows a pin change two clock edges after the change, and not after one.
- R4: The direction word (0x08) drives `pin_oe` one edge after it is written. `pin_out` carries the output word (0x04) only on lines whose direction bit is 1, and is 0 elsewhere.
- R5: With edge bit (0x14) 0, a line is level sensitive: active while the synchronised pin equals its polarity bit (0x10). The routed output goes high on the third edge after the pin change and stays high while the level holds.
- R6: With edge bit 1, polarity 1 selects rising and polarity 0 selects falling. The routed output is high for exactly one cycle, after the third edge following the selected transition. The opposite transition has no effect.
- R7: A line contributes only while its bit in the enable word (0x0C) is 1. Clearing a bit silences that line on the second edge after the write and leaves the other lines unchanged.
- R8: Line n is routed by byte (n mod 4) of the word at 0x20 + 4*(n/4). The byte value is the output index, and values of NOUT or more route nowhere. Lines that share an index are ORed onto that output.
- R9: A line count parameter outside 1..32 behaves as 32 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Raw pad inputs |
| pin_out | output | 32 | Output values, forced to 0 on input lines |
| pin_oe | output | 32 | Output enables (direction) |
| irq_out | output | NOUT | Registered interrupt outputs |

## Verification
A corrupted enable, polarity or routing field shows at the ports on the second edge after the register is written. It appears as an interrupt on the wrong output or as an interrupt that should not be there. A bad synchroniser or edge-history stage moves an edge pulse by a cycle or stretches it. A pulse that fires on the wrong transition is visible only in the single cycle the bench samples. For that reason every edge and level case is checked at the exact cycle it should rise, and again one cycle before or after it.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int NLINES = 8,
  parameter int NOUT   = 4,
  parameter int AW     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [31:0]     pin_in,
  output logic [31:0]     pin_out,
  output logic [31:0]     pin_oe,
  output logic [NOUT-1:0] irq_out
);
  localparam int NL = (NLINES < 1 || NLINES > 32) ? 32 : NLINES;
  localparam logic [31:0] LMASK = (NL == 32) ? 32'hFFFF_FFFF : ((32'h1 << NL) - 32'h1);

  logic [31:0] s1, s2, s3;
  logic [31:0] out_r, dir_r, mask_r, pol_r, edge_r;
  logic [255:0] map_v;
  logic [NOUT-1:0] want;
  wire  [AW-3:0] widx = bus_addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      out_r <= '0; dir_r <= '0; mask_r <= '0; pol_r <= '0; edge_r <= '0;
    end else begin
      s1 <= pin_in & LMASK;
      s2 <= s1;
      s3 <= s2;
      if (bus_we) begin
        case (widx)
          (AW-2)'(1): out_r  <= bus_wdata & LMASK;
          (AW-2)'(2): dir_r  <= bus_wdata & LMASK;
          (AW-2)'(3): mask_r <= bus_wdata & LMASK;
          (AW-2)'(4): pol_r  <= bus_wdata & LMASK;
          (AW-2)'(5): edge_r <= bus_wdata & LMASK;
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 0; n < 32; n++) begin : g_line
    if (n < NL) begin : g_on
      localparam logic [AW-3:0] WI = (AW-2)'(8 + n / 4);
      logic [7:0] fld;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld <= '0;
        else if (bus_we && widx == WI) fld <= bus_wdata[8*(n%4) +: 8];
      end
      assign map_v[8*n +: 8] = fld;
    end else begin : g_off
      assign map_v[8*n +: 8] = 8'h00;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      (AW-2)'(0): bus_rdata = s2;
      (AW-2)'(1): bus_rdata = out_r;
      (AW-2)'(2): bus_rdata = dir_r;
      (AW-2)'(3): bus_rdata = mask_r;
      (AW-2)'(4): bus_rdata = pol_r;
      (AW-2)'(5): bus_rdata = edge_r;
      default:
        if (widx >= (AW-2)'(8) && widx < (AW-2)'(16))
          bus_rdata = map_v[{widx[2:0], 5'b0} +: 32];
    endcase
  end

  wire [31:0] rise = s2 & ~s3;
  wire [31:0] fall = ~s2 & s3;
  wire [31:0] lvl  = (pol_r & s2) | (~pol_r & ~s2);
  wire [31:0] edg  = (pol_r & rise) | (~pol_r & fall);
  wire [31:0] act  = mask_r & ((edge_r & edg) | (~edge_r & lvl));

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    logic [31:0] sel;
    for (genvar n = 0; n < 32; n++) begin : g_sel
      assign sel[n] = (map_v[8*n +: 8] == 8'(j));
    end
    assign want[j] = |(act & sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= want;
  end

  assign pin_oe  = dir_r;
  assign pin_out = out_r & dir_r;
endmodule

module gpio_irq_router_chk #(
  parameter int NLINES = 8,
  parameter int NOUT   = 4,
  parameter int AW     = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     pin_oe,
  input logic [31:0]     mask_r,
  input logic [NOUT-1:0] irq_out
);
  localparam int CL = (NLINES < 1 || NLINES > 32) ? 32 : NLINES;
  localparam logic [31:0] LIVE = (CL == 32) ? 32'hFFFF_FFFF : ((32'h1 << CL) - 32'h1);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == '0);

  a_r2_upper_oe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~LIVE) == 32'h0);

  a_r4_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == (AW-2)'(2)) |=> pin_oe == ($past(bus_wdata) & LIVE));

  a_r7_cleared_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:2] == (AW-2)'(3) && bus_wdata == 32'h0) |=> ##1 irq_out == '0);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out != '0 |-> $past(mask_r) != 32'h0);
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NLINES(NLINES), .NOUT(NOUT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_oe(pin_oe), .mask_r(mask_r), .irq_out(irq_out)
);

// File: tb/tb_gpio_irq_router.sv
`timescale 1ns/1ps
module tb_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rdata, rdata2, pout, poe, pout2, poe2;
  logic [3:0]  irq, irq2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_router #(.NLINES(8), .NOUT(4), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pout), .pin_oe(poe), .irq_out(irq));

  gpio_irq_router #(.NLINES(40), .NOUT(4), .AW(8)) dut_wide (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rdata2), .pin_in(pin_in), .pin_out(pout2), .pin_oe(poe2), .irq_out(irq2));

  typedef struct { int src; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.src)
        0: act = rdata;
        1: act = rdata2;
        2: act = pout;
        3: act = poe;
        default: act = {28'h0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic chk(int src, logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.src = src; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    for (int a = 0; a < 24; a += 4) chk(0, 8'(a), 32'h0, "R1 reg reset");
    chk(0, 8'h20, 32'h0, "R1 map reset");
    chk(3, 8'h00, 32'h0, "R1 oe reset");
    chk(4, 8'h00, 32'h0, "R1 irq reset");

    // R2 / R9 widths, R4 drive
    wr(8'h04, 32'hFFFF_FFFF);
    chk(0, 8'h04, 32'h0000_00FF, "R2 out upper bits");
    chk(1, 8'h04, 32'hFFFF_FFFF, "R9 wide fallback");
    wr(8'h08, 32'h0000_000F);
    chk(3, 8'h00, 32'h0000_000F, "R4 oe");
    chk(2, 8'h00, 32'h0000_000F, "R4 out gated by dir");
    wr(8'h04, 32'h0000_0005);
    chk(2, 8'h00, 32'h0000_0005, "R4 out value");
    wr(8'h18, 32'hFFFF_FFFF);
    chk(0, 8'h18, 32'h0, "R2 bypass word");
    chk(0, 8'h1C, 32'h0, "R2 unused word");

    // R3 sync latency
    pin_in = 32'hFFFF_FF5A;
    tick(3);
    chk(0, 8'h00, 32'h0000_005A, "R3 read settled, R2 upper");
    pin_in = 32'h0000_00A5;
    tick();
    chk(0, 8'h00, 32'h0000_005A, "R3 one edge");
    tick();
    chk(0, 8'h00, 32'h0000_00A5, "R3 two edges");
    pin_in = 32'h0;
    tick(3);

    // R8 routing config
    wr(8'h10, 32'h0000_0012);
    wr(8'h14, 32'h0000_0030);
    wr(8'h20, 32'hFF01_0200);
    wr(8'h24, 32'h00FF_0303);
    wr(8'h28, 32'hFFFF_FFFF);
    chk(0, 8'h20, 32'hFF01_0200, "R8 map word0");
    chk(0, 8'h24, 32'h00FF_0303, "R8 map word1");
    chk(0, 8'h28, 32'h0, "R2 absent map word");

    // R5 level high, line 1 -> out 2
    wr(8'h0C, 32'h0000_0002);
    chk(4, 8'h00, 32'h0, "R5 idle");
    pin_in = 32'h02;
    tick(2);
    chk(4, 8'h00, 32'h0, "R5 level before");
    tick();
    chk(4, 8'h00, 32'h4, "R5 level high asserted");
    tick(4);
    chk(4, 8'h00, 32'h4, "R5 level held");
    pin_in = 32'h0;
    tick(2);
    chk(4, 8'h00, 32'h4, "R5 level still");
    tick();
    chk(4, 8'h00, 32'h0, "R5 level released");

    // R5 level low line 2 -> out 1, R7 per line
    wr(8'h0C, 32'h0000_0006);
    chk(4, 8'h00, 32'h0, "R7 enable latency");
    tick();
    chk(4, 8'h00, 32'h2, "R5 level low");
    pin_in = 32'h02;
    tick(3);
    chk(4, 8'h00, 32'h6, "R8 two outputs");
    wr(8'h0C, 32'h0000_0002);
    chk(4, 8'h00, 32'h6, "R7 disable latency");
    tick();
    chk(4, 8'h00, 32'h4, "R7 other line kept");
    pin_in = 32'h0;
    tick(3);
    chk(4, 8'h00, 32'h0, "R5 quiet");

    // R6 edges: line4 rising, line5 falling, both -> out 3
    wr(8'h0C, 32'h0000_0030);
    tick(2);
    chk(4, 8'h00, 32'h0, "R6 no spurious");
    pin_in = 32'h10;
    tick(2);
    chk(4, 8'h00, 32'h0, "R6 rise early");
    tick();
    chk(4, 8'h00, 32'h8, "R6 rise pulse");
    tick();
    chk(4, 8'h00, 32'h0, "R6 rise one cycle");
    pin_in = 32'h30;
    tick(3);
    chk(4, 8'h00, 32'h0, "R6 falling line ignores rise");
    tick(2);
    chk(4, 8'h00, 32'h0, "R6 falling line quiet");
    pin_in = 32'h10;
    tick(3);
    chk(4, 8'h00, 32'h8, "R6 fall pulse shared R8");
    tick();
    chk(4, 8'h00, 32'h0, "R6 fall one cycle");
    pin_in = 32'h00;
    tick(3);
    chk(4, 8'h00, 32'h0, "R6 rising line ignores fall");
    tick();
    chk(4, 8'h00, 32'h0, "R6 still quiet");

    // R8 unrouted line 6 level high
    wr(8'h10, 32'h0000_0052);
    wr(8'h0C, 32'h0000_0040);
    pin_in = 32'h40;
    tick(5);
    chk(4, 8'h00, 32'h0, "R8 unrouted line");
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    chk(0, 8'h0C, 32'h0000_00FF, "R2 enable upper bits");
    wr(8'h0C, 32'h0);
    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule